// File: doc/BRIEF.md
# Strapped Port Scan Sequencer

This block steps through a row of multiplexer port slots, one slot per word period. A fixed configuration vector has one bit per port. A 1 on a port makes that port open a new active channel. A 0 makes the port one more slot of the channel opened most recently. So a single channel can own a run of neighbouring slots.

For every slot the block drives the address of the channel that owns the slot, and that channel receives the gated clock. It pulses an end-of-scan strobe in the last clock cycle of each word. It pulses a frame-done strobe at the end of the last slot in use, and then the scan starts again at port 1.

A second configuration value sets the highest port in use. An external error flag is passed to the status output during one chosen slot only and is held inactive at every other slot.

Top module: `port_scan_seq`

## Requirements
- R1: While synchronous reset `rst` is high and at the first sample after reset, `portNum` is 1, `chanAddr` is 1, and `endOfScan`, `frameDone` and `errStatus` are all 0.
- R2: `endOfScan` is high for exactly one clock cycle per word: in the last cycle of each word, every WORD_CYCLES (default 4) cycles.
- R3: `portNum` holds its value through a word and goes up by one after each `endOfScan`, except at the frame end.
- R4: When the scan enters port p (p from 2 to 31), `chanAddr` goes up by one if `strapCfg[p-1]` is 1. It keeps its value if that bit is 0.
- R5: Port 1 always carries channel 1, whatever value `strapCfg[0]` has.
- R6: `chanAddr` never goes above 15. Any 1-bit in `strapCfg` after the fifteenth channel start is treated as an extension port.
- R7: The effective last port is `portsInUse` clamped to the range 15 to 31. A value below 15 acts as 15, and a value above 31 acts as 31.
- R8: `frameDone` is high for one cycle, together with the `endOfScan` of the last port in use. In the next cycle `portNum` is 1 and `chanAddr` is 1.
- R9: `errStatus` equals `errIn` while `portNum` is 24 (ERR_WORD). At every other port it is 0, even when `errIn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strapCfg | input | 31 | Bit p-1 is the strap for port p: 1 opens a channel, 0 extends the current one |
| portsInUse | input | 6 | Highest port in use before clamping |
| errIn | input | 1 | Error flag from the card's fault detection |
| portNum | output | 6 | Current port slot, from 1 up to the effective last port |
| chanAddr | output | 4 | Address of the active channel for the current slot |
| endOfScan | output | 1 | One-cycle pulse in the last cycle of each word |
| frameDone | output | 1 | One-cycle pulse at the end of the last slot in use |
| errStatus | output | 1 | Error flag, passed through only during slot 24 |

## Verification
The bench runs several strap patterns:
- An all-zero pattern with the port 1 strap cleared. A design that honoured that bit, or that counted zeros, would show a channel other than 1.
- An all-ones pattern. This pushes the channel count to its ceiling, where a missing cap would wrap the 4-bit address back to 0.

It sets `portsInUse` to 5, 0, 40 and 20. A missing clamp would wrap the scan early, or run it to port 40 and beyond. It holds `errIn` high through whole frames. A design that did not gate the flag by slot would raise `errStatus` on every word, and one that used the wrong slot would raise it away from port 24.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Strobes sent from the control to the datapath
  typedef struct packed {
    logic wordEnd;   // last cycle of the current word
    logic frameEnd;  // last cycle of the last port in use
  } scan_strobe_t;

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int WORD_CYCLES = 4,
  parameter int NUM_PORTS   = 31,
  parameter int MIN_PORTS   = 15,
  parameter int IDX_W       = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] portsInUse,
  output scan_strobe_t     strobe,
  output logic [IDX_W-1:0] portIdx,
  output logic [IDX_W-1:0] nextPort
);

  localparam int CYC_W = (WORD_CYCLES > 2) ? $clog2(WORD_CYCLES) : 1;
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(WORD_CYCLES - 1);

  logic [CYC_W-1:0] cycleCnt;
  logic [IDX_W-1:0] lastPort;

  // Clamp the configured port count to the legal range
  always_comb begin
    if (portsInUse < IDX_W'(MIN_PORTS))
      lastPort = IDX_W'(MIN_PORTS);
    else if (portsInUse > IDX_W'(NUM_PORTS))
      lastPort = IDX_W'(NUM_PORTS);
    else
      lastPort = portsInUse;
  end

  always_comb begin
    strobe.wordEnd  = (cycleCnt == LAST_CYC);
    strobe.frameEnd = strobe.wordEnd && (portIdx >= lastPort);
    nextPort        = strobe.frameEnd ? IDX_W'(1) : portIdx + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cycleCnt <= '0;
      portIdx  <= IDX_W'(1);
    end else begin
      cycleCnt <= strobe.wordEnd ? '0 : cycleCnt + CYC_W'(1);
      if (strobe.wordEnd)
        portIdx <= nextPort;
    end
  end

endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int NUM_PORTS    = 31,
  parameter int MAX_CHANNELS = 15,
  parameter int ERR_WORD     = 24,
  parameter int IDX_W        = 6,
  parameter int CHAN_W       = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  scan_strobe_t         strobe,
  input  logic [IDX_W-1:0]     portIdx,
  input  logic [IDX_W-1:0]     nextPort,
  input  logic [NUM_PORTS-1:0] strapCfg,
  input  logic                 errIn,
  output logic [CHAN_W-1:0]    chanAddr,
  output logic                 errStatus
);

  localparam int PAD_W = 1 << IDX_W;

  logic [PAD_W-1:0] strapPad;
  logic [IDX_W-1:0] strapSel;
  logic             opensChan;

  always_comb begin
    strapPad  = PAD_W'(strapCfg);
    strapSel  = nextPort - IDX_W'(1);
    opensChan = strapPad[strapSel] && (chanAddr < CHAN_W'(MAX_CHANNELS));
    errStatus = errIn && (portIdx == IDX_W'(ERR_WORD));
  end

  always_ff @(posedge clk) begin
    if (rst)
      chanAddr <= CHAN_W'(1);
    else if (strobe.wordEnd) begin
      if (strobe.frameEnd)
        chanAddr <= CHAN_W'(1);
      else if (opensChan)
        chanAddr <= chanAddr + CHAN_W'(1);
    end
  end

endmodule

// File: rtl/port_scan_seq.sv
module port_scan_seq
  import scan_pkg::*;
#(
  parameter int WORD_CYCLES  = 4,
  parameter int NUM_PORTS    = 31,
  parameter int MIN_PORTS    = 15,
  parameter int MAX_CHANNELS = 15,
  parameter int ERR_WORD     = 24,
  parameter int IDX_W        = $clog2(NUM_PORTS + 1) + 1,
  parameter int CHAN_W       = $clog2(MAX_CHANNELS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] strapCfg,
  input  logic [IDX_W-1:0]     portsInUse,
  input  logic                 errIn,
  output logic [IDX_W-1:0]     portNum,
  output logic [CHAN_W-1:0]    chanAddr,
  output logic                 endOfScan,
  output logic                 frameDone,
  output logic                 errStatus
);

  scan_strobe_t     strobe;
  logic [IDX_W-1:0] nextPort;

  scan_ctrl #(
    .WORD_CYCLES(WORD_CYCLES), .NUM_PORTS(NUM_PORTS),
    .MIN_PORTS(MIN_PORTS), .IDX_W(IDX_W)
  ) i_ctrl (
    .clk(clk), .rst(rst), .portsInUse(portsInUse),
    .strobe(strobe), .portIdx(portNum), .nextPort(nextPort)
  );

  scan_datapath #(
    .NUM_PORTS(NUM_PORTS), .MAX_CHANNELS(MAX_CHANNELS),
    .ERR_WORD(ERR_WORD), .IDX_W(IDX_W), .CHAN_W(CHAN_W)
  ) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .portIdx(portNum),
    .nextPort(nextPort), .strapCfg(strapCfg), .errIn(errIn),
    .chanAddr(chanAddr), .errStatus(errStatus)
  );

  assign endOfScan = strobe.wordEnd;
  assign frameDone = strobe.frameEnd;

endmodule

// File: rtl/port_scan_seq_chk.sv
module port_scan_seq_chk #(
  parameter int MAX_CHANNELS = 15,
  parameter int ERR_WORD     = 24,
  parameter int IDX_W        = 6,
  parameter int CHAN_W       = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              errIn,
  input logic [IDX_W-1:0]  portNum,
  input logic [CHAN_W-1:0] chanAddr,
  input logic              endOfScan,
  input logic              frameDone,
  input logic              errStatus
);

  a_r2_eos_one_cycle: assert property (@(posedge clk) disable iff (rst)
    endOfScan |=> !endOfScan);

  a_r3_port_steps: assert property (@(posedge clk) disable iff (rst)
    (endOfScan && !frameDone) |=> (portNum == $past(portNum) + IDX_W'(1)));

  a_r3_port_holds: assert property (@(posedge clk) disable iff (rst)
    !endOfScan |=> $stable(portNum));

  a_r4_chan_step_small: assert property (@(posedge clk) disable iff (rst)
    (endOfScan && !frameDone) |=> (chanAddr - $past(chanAddr) <= CHAN_W'(1)));

  a_r4_chan_holds: assert property (@(posedge clk) disable iff (rst)
    !endOfScan |=> $stable(chanAddr));

  a_r6_chan_range: assert property (@(posedge clk) disable iff (rst)
    (chanAddr >= CHAN_W'(1)) && (chanAddr <= CHAN_W'(MAX_CHANNELS)));

  a_r8_frame_with_eos: assert property (@(posedge clk) disable iff (rst)
    frameDone |-> endOfScan);

  a_r8_wrap_to_start: assert property (@(posedge clk) disable iff (rst)
    frameDone |=> (portNum == IDX_W'(1)) && (chanAddr == CHAN_W'(1)));

  a_r9_err_only_slot: assert property (@(posedge clk) disable iff (rst)
    (portNum != IDX_W'(ERR_WORD) || !errIn) |-> !errStatus);

endmodule

bind port_scan_seq port_scan_seq_chk #(
  .MAX_CHANNELS(MAX_CHANNELS), .ERR_WORD(ERR_WORD),
  .IDX_W(IDX_W), .CHAN_W(CHAN_W)
) i_chk (
  .clk(clk), .rst(rst), .errIn(errIn), .portNum(portNum),
  .chanAddr(chanAddr), .endOfScan(endOfScan),
  .frameDone(frameDone), .errStatus(errStatus)
);

// File: tb/test_port_scan_seq.sv
module test_port_scan_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_CYC   = 4;
  localparam int NPORTS     = 31;
  localparam int IW         = 6;
  localparam int CW         = 4;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic [IW-1:0] port;
    logic [CW-1:0] chan;
    logic          frame;
    logic          err;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NPORTS-1:0] strapCfg = '0;
  logic [IW-1:0]     portsInUse = IW'(15);
  logic              errIn = 1'b0;
  logic [IW-1:0]     portNum;
  logic [CW-1:0]     chanAddr;
  logic              endOfScan;
  logic              frameDone;
  logic              errStatus;

  int   nTests = 0;
  int   nFail  = 0;
  int   cycSinceEos = 0;
  int   cycles = 0;
  exp_t expQ[$];

  port_scan_seq i_port_scan_seq (
    .clk(clk), .rst(rst), .strapCfg(strapCfg), .portsInUse(portsInUse),
    .errIn(errIn), .portNum(portNum), .chanAddr(chanAddr),
    .endOfScan(endOfScan), .frameDone(frameDone), .errStatus(errStatus)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Monitor: compares each word's outputs at its end-of-scan cycle
  always @(negedge clk) begin
    cycles++;
    if (rst) cycSinceEos = 0;
    else begin
      cycSinceEos++;
      if (frameDone && !endOfScan) check("R8 frameDone without endOfScan", 1, 0);
      if (!endOfScan && errStatus && portNum != IW'(24))
        check("R9 errStatus outside slot 24", 1, 0);
      if (endOfScan) begin
        check("R2 word length", cycSinceEos, WORD_CYC);
        cycSinceEos = 0;
        if (expQ.size() == 0) check("R3 unexpected word", 1, 0);
        else begin
          exp_t e;
          e = expQ.pop_front();
          check("R3 port", int'(portNum), int'(e.port));
          check("R4 chan", int'(chanAddr), int'(e.chan));
          check("R8 frameDone", int'(frameDone), int'(e.frame));
          check("R9 errStatus", int'(errStatus), int'(e.err));
        end
      end
    end
  end

  function automatic int clampLimit(input int v);
    if (v < 15) return 15;
    if (v > 31) return 31;
    return v;
  endfunction

  // Driver: reset, apply config, queue the expected words, wait for drain
  task automatic runCase(input logic [NPORTS-1:0] s, input int piu,
                         input logic e, input int frames);
    int lim;
    @(posedge clk); #1;
    rst = 1'b1; strapCfg = s; portsInUse = IW'(piu); errIn = e;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset port", int'(portNum), 1);
    check("R1 reset chan", int'(chanAddr), 1);
    check("R1 reset eos", int'(endOfScan), 0);
    check("R1 reset frameDone", int'(frameDone), 0);
    check("R1 reset errStatus", int'(errStatus), 0);
    lim = clampLimit(piu);
    for (int f = 0; f < frames; f++) begin
      int ch = 1;
      for (int p = 1; p <= lim; p++) begin
        exp_t x;
        if (p >= 2 && s[p-1] && ch < 15) ch++;   // R4, R5, R6
        x.port  = IW'(p);
        x.chan  = CW'(ch);
        x.frame = (p == lim);                    // R7, R8
        x.err   = e && (p == 24);                // R9
        expQ.push_back(x);
      end
    end
    @(posedge clk); #1;
    rst = 1'b0;
    while (expQ.size() != 0) @(posedge clk);
  endtask

  initial begin
    // R5: port 1 strap cleared, all extensions, minimum length
    runCase(31'h0, 15, 1'b0, 2);
    // R6, R9: every port opens a channel, full length, error held high
    runCase({31{1'b1}}, 31, 1'b1, 2);
    // R4: mixed pattern, 20 ports, slot 24 never reached
    runCase(31'h2C5_3A91, 20, 1'b1, 2);
    // R7: clamp from below and above
    runCase(31'h0F0_F00F, 5, 1'b0, 1);
    runCase(31'h0F0_F00F, 0, 1'b1, 1);
    runCase(31'h555_5555, 40, 1'b1, 2);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    wait (cycles > WATCHDOG);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule